// File: doc/BRIEF.md
# Two-Wire Controller Host Register Bank with Interrupt Aggregation

This block is the byte-wide host register file of a two-wire serial bus controller. A host reaches it through a simple synchronous bus with a 5-bit byte address, separate write and read strobes, and read data returned one cycle after the read strobe. The 32-byte window has a common part that is always visible. Its upper part at offsets 0x10 to 0x1E shows one of two register sets, and bit 5 of the line-control register at 0x0E selects which set appears. The offsets 0x18, 0x19 and 0x1F stay common in both banks.

The transfer sequencer and the receive buffer are outside this block. They report events through one-cycle set and clear strobes on the status bits. They receive start, stop and buffer-clear commands as one-cycle pulses, which the host requests by writing command bits that are never stored.

The block applies each bit's write rule: plain storage, write-one-to-clear, write-one-to-set, read-only, or ignored. It combines the enabled status conditions into one registered, level-sensitive interrupt line, and the host can read that line back as a pending flag.

Top module: `tw_hostreg`

## Requirements
- R1: After reset, the registers read: 0x04 = 0x10, 0x0E = 0xC0, bank-0 0x1A = 0x07, bank-1 0x14 = 0x3F, bank-1 0x1E = 0x01, 0x1F = 0x81. Every other mapped register reads 0x00, and `irq` is 0.
- R2: When bit 5 of 0x0E is 0, offsets 0x10–0x1E reach bank 0, where 0x10–0x17 are eight address bytes. When that bit is 1, they reach bank 1, where 0x11 is a plain byte. Offsets 0x00–0x0E, 0x18, 0x19 and 0x1F reach the same registers in both banks.
- R3: In the status register at 0x02, writing 1 clears bits 7, 5, 4, 3 and 2, and writing 0 leaves them unchanged. Bits 6, 1 and 0 ignore host writes. All eight bits are set and cleared by `st_set` and `st_clr`.
- R4: In control register 0x06, bits 0, 1 and 4 always read 0. Bits 7, 6, 5, 3 and 2 are stored. Writing 1 to bit 0 pulses `cmd_start` and writing 1 to bit 1 pulses `cmd_stop`, each high for exactly the one cycle after the write.
- R5: Bits 7 and 6 of 0x0E ignore writes and read 1. Register 0x1F always reads 0x81, and writes to it have no effect.
- R6: Bit 7 of 0x18 reads the current `irq` level and bits 6:0 read 0. Writes to 0x18 have no effect.
- R7: `irq` is 0 whenever bit 2 of 0x06 is 0. When that bit is 1, status bits 5, 4 and 6 of 0x02 each raise `irq` without further gating.
- R8: Five further sources raise `irq` only when their own enable is also set. Status bit 2 is gated by 0x06 bit 6. Bit 7 of 0x19 is gated by 0x06 bit 3. Bank-1 0x1C bit 6 is gated by bank-1 0x1E bit 6. Bank-1 0x1A bit 6 is gated by bank-1 0x12 bit 6. Bank-1 0x10 bit 1 is gated by bank-1 0x10 bit 3. The flag bits 0x19 bit 7, 0x1C bit 6, 0x1A bit 6 and 0x10 bit 1 each clear when 1 is written to them.
- R9: Bit 7 of bank-1 0x14 is set by `tmo_set`. Writing 1 to it clears it, and writing 0 leaves it unchanged. Bits 6:0 of bank-1 0x14 are stored.
- R10: A set strobe takes priority over a host write-one-to-clear of the same bit in the same cycle, so the bit ends up set.
- R11: Reads of unmapped offsets return 0x00, for example 0x01 and bank-1 0x13, even after those offsets have been written.
- R12: In bank-1 0x1E, writing 1 to bit 5 sets it and writing 0 leaves it unchanged. In bank-1 0x10, writing 1 to bit 6 pulses `fifo_clr` for one cycle and clears bit 1, and bit 6 reads 0.
- R13: Read data appears on `host_rdata` in the cycle after the read strobe. `irq` changes one cycle after the status register that drives it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 5 | Byte address in the register window |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| st_set | input | 8 | Sequencer set strobes for status 0x02 |
| st_clr | input | 8 | Sequencer clear strobes for status 0x02 |
| bb_set | input | 1 | Sets bit 1 of 0x04 (bus busy) |
| eob_set | input | 1 | Sets end-of-busy flag, 0x19 bit 7 |
| fifo_flag_set | input | 1 | Sets buffer empty/full flag, bank-1 0x10 bit 1 |
| rx_thr_set | input | 1 | Sets receive-threshold flag, bank-1 0x1C bit 6 |
| tx_thr_set | input | 1 | Sets transmit-threshold flag, bank-1 0x1A bit 6 |
| tmo_set | input | 1 | Sets timeout flag, bank-1 0x14 bit 7 |
| cmd_start | output | 1 | One-cycle start command |
| cmd_stop | output | 1 | One-cycle stop command |
| fifo_clr | output | 1 | One-cycle buffer-clear command |
| irq | output | 1 | Registered level interrupt |

## Verification
The interrupt equation is tried with each source asserted alone, first with its gate off and then with its gate on. It is also tried with the global enable cleared while an ungated source is active. Together these patterns show an ungated source apart from a gated one, and show that each gate is tied to its own source rather than a neighbour's. Bank decoding is tried by writing distinct bytes to the same offset in both banks and to a common offset, which shows a bank swap apart from aliasing. The bit rules are tried with all-zero and all-one writes over fully set registers, and with a set strobe racing a clear in the same cycle.

// File: rtl/tw_hostreg_pkg.sv
// Package: register layout of the two-wire controller host window.
// Each register is described by one configuration record. The record gives its
// offset, whether it is banked, its reset value and the write rule of every bit.
package tw_hostreg_pkg;

    localparam int AW   = 5;
    localparam int DW   = 8;
    localparam int NREG = 31;

    typedef struct packed {
        logic [AW-1:0] off;     // byte offset in the window
        logic          banked;  // 1: visible only in bank 'bank'
        logic          bank;
        logic [DW-1:0] rst;     // reset value
        logic [DW-1:0] store;   // bits loaded from write data
        logic [DW-1:0] w1c;     // bits cleared by writing 1
        logic [DW-1:0] w1s;     // bits set by writing 1 (write 0 keeps)
    } reg_cfg_t;

    // Register indices used by the special logic around the generic cells
    localparam int RI_DATA  = 0;
    localparam int RI_STAT  = 1;
    localparam int RI_CST   = 2;
    localparam int RI_CTL1  = 3;
    localparam int RI_CTL3  = 7;
    localparam int RI_CST2  = 8;
    localparam int RI_CST3  = 9;
    localparam int RI_FIFCS = 24;
    localparam int RI_TXCTL = 26;
    localparam int RI_TMO   = 27;
    localparam int RI_TXST  = 28;
    localparam int RI_RXST  = 29;
    localparam int RI_RXCTL = 30;

    // Layout function; indices 11..18 are the eight bank-0 address bytes
    function automatic reg_cfg_t reg_cfg(input int i);
        reg_cfg_t c;
        c = '{off: '0, banked: 1'b0, bank: 1'b0, rst: '0, store: 8'hFF, w1c: '0, w1s: '0};
        case (i)
            0:  c.off = 5'h00;
            1:  begin c.off = 5'h02; c.store = 8'h00; c.w1c = 8'hBC; end
            2:  begin c.off = 5'h04; c.rst = 8'h10; c.store = 8'h00; c.w1c = 8'h02; end
            3:  begin c.off = 5'h06; c.store = 8'hEC; end
            4:  c.off = 5'h08;
            5:  c.off = 5'h0A;
            6:  c.off = 5'h0C;
            7:  begin c.off = 5'h0E; c.rst = 8'hC0; c.store = 8'h3F; end
            8:  begin c.off = 5'h18; c.store = 8'h00; end
            9:  begin c.off = 5'h19; c.store = 8'h00; c.w1c = 8'h80; end
            10: begin c.off = 5'h1F; c.rst = 8'h81; c.store = 8'h00; end
            19: begin c.off = 5'h1A; c.banked = 1'b1; c.rst = 8'h07; end
            20: begin c.off = 5'h1B; c.banked = 1'b1; end
            21: begin c.off = 5'h1C; c.banked = 1'b1; end
            22: begin c.off = 5'h1D; c.banked = 1'b1; c.store = 8'hFC; c.w1c = 8'h02; end
            23: begin c.off = 5'h1E; c.banked = 1'b1; end
            24: begin c.off = 5'h10; c.banked = 1'b1; c.bank = 1'b1; c.store = 8'h08; c.w1c = 8'h82; end
            25: begin c.off = 5'h11; c.banked = 1'b1; c.bank = 1'b1; end
            26: begin c.off = 5'h12; c.banked = 1'b1; c.bank = 1'b1; end
            27: begin c.off = 5'h14; c.banked = 1'b1; c.bank = 1'b1; c.rst = 8'h3F;
                      c.store = 8'h7F; c.w1c = 8'h80; end
            28: begin c.off = 5'h1A; c.banked = 1'b1; c.bank = 1'b1; c.store = 8'h00; c.w1c = 8'h40; end
            29: begin c.off = 5'h1C; c.banked = 1'b1; c.bank = 1'b1; c.store = 8'h00; c.w1c = 8'h40; end
            30: begin c.off = 5'h1E; c.banked = 1'b1; c.bank = 1'b1; c.rst = 8'h01;
                      c.store = 8'hDF; c.w1s = 8'h20; end
            default: begin
                // bank-0 address bytes at 0x10..0x17
                c.off    = AW'(16 + i - 11);
                c.banked = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tw_reg_decode.sv
// Address decoder: turns the byte address and the current bank into one hit
// line per register. Assumes the layout in tw_hostreg_pkg has no two registers
// that are visible at the same offset in the same bank.
module tw_reg_decode
    import tw_hostreg_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic [AW-1:0] addr,
    input  logic          bank,
    output logic [N-1:0]  hit
);
    for (genvar i = 0; i < N; i++) begin : g_hit
        localparam reg_cfg_t C = reg_cfg(i);
        // One comparator per register, with the bank qualifier for banked ones
        assign hit[i] = (addr == C.off) && (!C.banked || (bank == C.bank));
    end
endmodule

// File: rtl/tw_reg_cell.sv
// One host register byte with per-bit write rules set by masks. Hardware set
// strobes win over every clear, and hardware clears win over host loads.
// Assumes the masks do not overlap for any bit.
module tw_reg_cell
    import tw_hostreg_pkg::*;
#(
    parameter logic [DW-1:0] RST   = '0,
    parameter logic [DW-1:0] STORE = '1,
    parameter logic [DW-1:0] W1C   = '0,
    parameter logic [DW-1:0] W1S   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] hw_set,
    input  logic [DW-1:0] hw_clr,
    output logic [DW-1:0] q
);
    logic [DW-1:0] q_n;

    // Next value: host load, host set and clear, then hardware clear and set
    always_comb begin
        q_n = q;
        if (wr) begin
            q_n = (q & ~STORE) | (wdata & STORE) | (wdata & W1S);
            q_n = q_n & ~(wdata & W1C);
        end
        q_n = (q_n & ~hw_clr) | hw_set;
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= q_n;
    end
endmodule

// File: rtl/tw_irq_agg.sv
// Interrupt aggregator: ORs the ungated sources with the gated sources that
// are enabled, qualifies the result with the global enable and registers it.
// Assumes all inputs are synchronous to clk.
module tw_irq_agg #(
    parameter int N_UNGATED = 3,
    parameter int N_GATED   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 global_en,
    input  logic [N_UNGATED-1:0] src_ungated,
    input  logic [N_GATED-1:0]   src_gated,
    input  logic [N_GATED-1:0]   src_en,
    output logic                 irq_q
);
    logic level;

    // Combined level of all active sources
    assign level = global_en && ((|src_ungated) || (|(src_gated & src_en)));

    // Registered output, low during reset
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= level;
    end
endmodule

// File: rtl/tw_hostreg.sv
// Host register window of a two-wire bus controller. It holds a common part
// and two banks selected by line-control bit 5, applies each bit's write rule,
// turns command bits into one-cycle pulses and drives a registered interrupt.
// Assumes one host access per cycle. A read strobe captures data at the clock
// edge, and the captured value is held until the next read.
module tw_hostreg
    import tw_hostreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_wr,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic [DW-1:0] st_set,
    input  logic [DW-1:0] st_clr,
    input  logic          bb_set,
    input  logic          eob_set,
    input  logic          fifo_flag_set,
    input  logic          rx_thr_set,
    input  logic          tx_thr_set,
    input  logic          tmo_set,
    output logic          cmd_start,
    output logic          cmd_stop,
    output logic          fifo_clr,
    output logic          irq
);
    logic [NREG-1:0] hit;
    logic [DW-1:0]   reg_q  [NREG];
    logic [DW-1:0]   hw_set [NREG];
    logic [DW-1:0]   hw_clr [NREG];
    logic [DW-1:0]   rd_mux;
    logic            bank;
    logic            wr_ctl1;
    logic            wr_fifcs;

    assign bank     = reg_q[RI_CTL3][5];
    assign wr_ctl1  = host_wr && hit[RI_CTL1];
    assign wr_fifcs = host_wr && hit[RI_FIFCS];

    tw_reg_decode #(.N(NREG)) u_decode (
        .addr (host_addr),
        .bank (bank),
        .hit  (hit)
    );

    // Routes the sequencer strobes to the bits they set or clear
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            hw_set[i] = '0;
            hw_clr[i] = '0;
        end
        hw_set[RI_STAT]     = st_set;
        hw_clr[RI_STAT]     = st_clr;
        hw_set[RI_CST][1]   = bb_set;
        hw_set[RI_CST3][7]  = eob_set;
        hw_set[RI_FIFCS][1] = fifo_flag_set;
        hw_clr[RI_FIFCS][1] = wr_fifcs && host_wdata[6];
        hw_set[RI_TMO][7]   = tmo_set;
        hw_set[RI_TXST][6]  = tx_thr_set;
        hw_set[RI_RXST][6]  = rx_thr_set;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam reg_cfg_t C = reg_cfg(i);
        tw_reg_cell #(
            .RST   (C.rst),
            .STORE (C.store),
            .W1C   (C.w1c),
            .W1S   (C.w1s)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (host_wr && hit[i]),
            .wdata  (host_wdata),
            .hw_set (hw_set[i]),
            .hw_clr (hw_clr[i]),
            .q      (reg_q[i])
        );
    end

    // Interrupt sources: ungated {data-ready, neg-ack, bus error}; gated in pairs
    tw_irq_agg #(.N_UNGATED(3), .N_GATED(5)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .global_en   (reg_q[RI_CTL1][2]),
        .src_ungated ({reg_q[RI_STAT][6], reg_q[RI_STAT][4], reg_q[RI_STAT][5]}),
        .src_gated   ({reg_q[RI_STAT][2], reg_q[RI_CST3][7], reg_q[RI_RXST][6],
                       reg_q[RI_TXST][6], reg_q[RI_FIFCS][1]}),
        .src_en      ({reg_q[RI_CTL1][6], reg_q[RI_CTL1][3], reg_q[RI_RXCTL][6],
                       reg_q[RI_TXCTL][6], reg_q[RI_FIFCS][3]}),
        .irq_q       (irq)
    );

    // AND-OR read multiplexer; pending flag merged into 0x18 bit 7
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) rd_mux = rd_mux | reg_q[i];
        end
        if (hit[RI_CST2]) rd_mux = rd_mux | {irq, {(DW-1){1'b0}}};
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    // Command pulses from unstored command bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start <= 1'b0;
            cmd_stop  <= 1'b0;
            fifo_clr  <= 1'b0;
        end else begin
            cmd_start <= wr_ctl1 && host_wdata[0];
            cmd_stop  <= wr_ctl1 && host_wdata[1];
            fifo_clr  <= wr_fifcs && host_wdata[6];
        end
    end
endmodule

// File: rtl/tw_hostreg_chk.sv
// Checker for tw_hostreg: port-level and state properties, bound to the top.
module tw_hostreg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_rdata,
    input logic [7:0] st_set,
    input logic       cmd_start,
    input logic       irq,
    input logic [7:0] ctl1_q,
    input logic [7:0] st_q,
    input logic [7:0] ctl3_q
);
    a_r4_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(host_wr && host_addr == 5'h06 && host_wdata[0]));

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctl1_q[2]));

    a_r3_stop_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 5'h02 && host_wdata[7] && !st_set[7]) |=> !st_q[7]);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        st_set[5] |=> st_q[5]);

    a_r5_version: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 5'h1F) |=> host_rdata == 8'h81);

    a_r5_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ctl3_q[7:6] == 2'b11);

    a_r6_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 5'h18) |=> host_rdata == {$past(irq), 7'b0});
endmodule

bind tw_hostreg tw_hostreg_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .st_set     (st_set),
    .cmd_start  (cmd_start),
    .irq        (irq),
    .ctl1_q     (reg_q[tw_hostreg_pkg::RI_CTL1]),
    .st_q       (reg_q[tw_hostreg_pkg::RI_STAT]),
    .ctl3_q     (reg_q[tw_hostreg_pkg::RI_CTL3])
);

// File: tb/test_tw_hostreg.sv
// Directed bench for tw_hostreg: one task per scenario, each checking itself.
module test_tw_hostreg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic [7:0] st_set = '0;
    logic [7:0] st_clr = '0;
    logic       bb_set = 1'b0, eob_set = 1'b0, fifo_flag_set = 1'b0;
    logic       rx_thr_set = 1'b0, tx_thr_set = 1'b0, tmo_set = 1'b0;
    logic       cmd_start, cmd_stop, fifo_clr, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_hostreg i_tw_hostreg (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .st_set(st_set), .st_clr(st_clr), .bb_set(bb_set), .eob_set(eob_set),
        .fifo_flag_set(fifo_flag_set), .rx_thr_set(rx_thr_set),
        .tx_thr_set(tx_thr_set), .tmo_set(tmo_set), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .fifo_clr(fifo_clr), .irq(irq));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    // misc = {tmo, tx_thr, rx_thr, fifo_flag, eob, bb}
    task automatic strobe(input logic [7:0] s, input logic [7:0] c, input logic [5:0] misc);
        @(negedge clk);
        st_set = s; st_clr = c;
        {tmo_set, tx_thr_set, rx_thr_set, fifo_flag_set, eob_set, bb_set} = misc;
        @(negedge clk);
        st_set = '0; st_clr = '0;
        {tmo_set, tx_thr_set, rx_thr_set, fifo_flag_set, eob_set, bb_set} = '0;
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        chk(req, {7'b0, irq}, {7'b0, exp});
    endtask

    task automatic t_reset;
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd_chk("R1 status", 5'h02, 8'h00);
        rd_chk("R1 ctrl-status", 5'h04, 8'h10);
        rd_chk("R1 line-control", 5'h0E, 8'hC0);
        rd_chk("R1 bank0 0x1A", 5'h1A, 8'h07);
        rd_chk("R1 version", 5'h1F, 8'h81);
        wr(5'h0E, 8'h20);
        rd_chk("R1 bank1 timeout", 5'h14, 8'h3F);
        rd_chk("R1 bank1 rx ctl", 5'h1E, 8'h01);
        wr(5'h0E, 8'h00);
    endtask

    task automatic t_bank;
        wr(5'h10, 8'hA5);
        wr(5'h11, 8'h3C);
        wr(5'h0E, 8'h20);
        wr(5'h11, 8'h5A);
        wr(5'h08, 8'h33);
        rd_chk("R2 bank1 0x11", 5'h11, 8'h5A);
        wr(5'h0E, 8'h00);
        rd_chk("R2 bank0 0x11 kept", 5'h11, 8'h3C);
        rd_chk("R2 bank0 0x10", 5'h10, 8'hA5);
        rd_chk("R2 common 0x08", 5'h08, 8'h33);
    endtask

    task automatic t_status;
        strobe(8'hFF, 8'h00, 6'b0);
        rd_chk("R3 all set", 5'h02, 8'hFF);
        chk("R7 no irq without enable", {7'b0, irq}, 8'h00);
        wr(5'h02, 8'h00);
        rd_chk("R3 write zero keeps", 5'h02, 8'hFF);
        wr(5'h02, 8'hFF);
        rd_chk("R3 w1c leaves 6,1,0", 5'h02, 8'h43);
        strobe(8'h00, 8'hFF, 6'b0);
        rd_chk("R3 hw clear", 5'h02, 8'h00);
    endtask

    task automatic t_ctl1;
        wr(5'h06, 8'hFF);
        chk("R4 start pulse", {7'b0, cmd_start}, 8'h01);
        chk("R4 stop pulse", {7'b0, cmd_stop}, 8'h01);
        @(negedge clk);
        chk("R4 start one cycle", {7'b0, cmd_start}, 8'h00);
        chk("R4 stop one cycle", {7'b0, cmd_stop}, 8'h00);
        rd_chk("R4 stored bits", 5'h06, 8'hEC);
        wr(5'h06, 8'h04);
    endtask

    task automatic t_irq;
        // enable only: ungated bus error
        strobe(8'h20, 8'h00, 6'b0);
        chk("R13 irq not yet", {7'b0, irq}, 8'h00);
        irq_chk("R7 bus error raises irq", 1'b1);
        rd_chk("R6 pending flag", 5'h18, 8'h80);
        wr(5'h02, 8'h20);
        irq_chk("R7 cleared", 1'b0);
        strobe(8'h10, 8'h00, 6'b0);
        irq_chk("R7 neg-ack raises irq", 1'b1);
        wr(5'h06, 8'h00);
        irq_chk("R7 global enable off", 1'b0);
        wr(5'h02, 8'h10);
        wr(5'h06, 8'h04);
        // no-match gated by ctl1 bit 6
        strobe(8'h04, 8'h00, 6'b0);
        irq_chk("R8 no-match gated off", 1'b0);
        wr(5'h06, 8'h44);
        irq_chk("R8 no-match gated on", 1'b1);
        wr(5'h02, 8'h04);
        wr(5'h06, 8'h04);
        // end-of-busy gated by ctl1 bit 3
        strobe(8'h00, 8'h00, 6'b000010);
        irq_chk("R8 end-of-busy gated off", 1'b0);
        wr(5'h06, 8'h0C);
        irq_chk("R8 end-of-busy gated on", 1'b1);
        wr(5'h19, 8'h80);
        irq_chk("R8 end-of-busy cleared", 1'b0);
        wr(5'h06, 8'h04);
        // bank-1 sources
        wr(5'h0E, 8'h20);
        strobe(8'h00, 8'h00, 6'b001000);
        irq_chk("R8 rx threshold gated off", 1'b0);
        wr(5'h1E, 8'h41);
        irq_chk("R8 rx threshold gated on", 1'b1);
        wr(5'h1C, 8'h40);
        irq_chk("R8 rx threshold cleared", 1'b0);
        strobe(8'h00, 8'h00, 6'b010000);
        irq_chk("R8 tx threshold gated off", 1'b0);
        wr(5'h12, 8'h40);
        irq_chk("R8 tx threshold gated on", 1'b1);
        wr(5'h1A, 8'h40);
        irq_chk("R8 tx threshold cleared", 1'b0);
        strobe(8'h00, 8'h00, 6'b000100);
        irq_chk("R8 fifo flag gated off", 1'b0);
        wr(5'h10, 8'h08);
        irq_chk("R8 fifo flag gated on", 1'b1);
        wr(5'h10, 8'h48);
        chk("R12 fifo clear pulse", {7'b0, fifo_clr}, 8'h01);
        irq_chk("R12 clear command drops flag", 1'b0);
        rd_chk("R12 fifo ctl reads", 5'h10, 8'h08);
        wr(5'h0E, 8'h00);
    endtask

    task automatic t_tmo;
        wr(5'h0E, 8'h20);
        strobe(8'h00, 8'h00, 6'b100000);
        rd_chk("R9 timeout set", 5'h14, 8'hBF);
        wr(5'h14, 8'h05);
        rd_chk("R9 write zero keeps flag", 5'h14, 8'h85);
        wr(5'h14, 8'h80);
        rd_chk("R9 w1c flag", 5'h14, 8'h00);
        wr(5'h1E, 8'h20);
        rd_chk("R12 last bit set", 5'h1E, 8'h20);
        wr(5'h1E, 8'h00);
        rd_chk("R12 last bit sticky", 5'h1E, 8'h20);
        wr(5'h13, 8'hFF);
        rd_chk("R11 bank1 0x13 unmapped", 5'h13, 8'h00);
        wr(5'h0E, 8'h00);
    endtask

    task automatic t_misc;
        @(negedge clk);
        st_set = 8'h80; host_wr = 1'b1; host_addr = 5'h02; host_wdata = 8'h80;
        @(negedge clk);
        st_set = '0; host_wr = 1'b0;
        rd_chk("R10 set wins", 5'h02, 8'h80);
        wr(5'h02, 8'h80);
        wr(5'h01, 8'hFF);
        rd_chk("R11 0x01 unmapped", 5'h01, 8'h00);
        wr(5'h1F, 8'h00);
        rd_chk("R5 version ignores write", 5'h1F, 8'h81);
        wr(5'h0E, 8'h00);
        rd_chk("R5 line levels ignore write", 5'h0E, 8'hC0);
        wr(5'h18, 8'hFF);
        rd_chk("R6 0x18 ignores write", 5'h18, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank();
        t_status();
        t_ctl1();
        t_irq();
        t_tmo();
        t_misc();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule